// File: doc/BRIEF.md
# UART Banked Control Register File

This block is the control-register slice of a UART-style peripheral. A host reaches it over a byte-wide bus with a 3-bit offset. It owns the modem control register at offset 4. It also owns two banked offsets. Offset 6 shows either the modem status lines or a trigger control byte. Offset 7 shows either a scratch byte or a trigger level byte. Which register an offset shows depends on the enhanced-features enable input (`feat_en`) and control bit 2. The trigger view is active only when both are 1. The control register drives the interrupt pin enable, a general-purpose output, internal loopback, the character-resume mode and the clock prescaler select.

A small transfer state machine classifies each cycle. XF_IDLE means no access. XF_WRITE is entered whenever `sel` and `wr_stb` are both high. XF_READ is entered when `sel` and `rd_stb` are high without `wr_stb`. Every state can move to every other state on the strobes of the current cycle. Writes land on the clock edge of XF_WRITE. The read byte is captured on the edge of XF_READ and is held until the next read. If both strobes are high together, the write takes priority and no read happens.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset, every stored register is 0, `rd_data` is 0, `irq_oe` is 0, `gpo` is 1, and `loop_en`, `any_resume` and `clk_div4` are 0.
- R2: A write to offset 4 stores control bits 0 to 4 directly. A read of offset 4 returns the stored control byte on `rd_data` after the clock edge that samples the read.
- R3: Control bits 5 and 7 take a written value only while `feat_en` is 1. Otherwise they keep their previous value.
- R4: Control bit 6 is reserved: it always reads 0, whatever was written.
- R5: A read of offset 6 returns the trigger control byte when `feat_en` and control bit 2 are both 1. Otherwise it returns the modem status.
- R6: Offset 7 reaches the trigger level byte when `feat_en` and control bit 2 are both 1, and the scratch byte otherwise. Reads and writes go to the selected byte only, and the two bytes are stored separately.
- R7: A write to offset 6 while the status view is selected changes no register.
- R8: When control bit 3 is 1, `irq_oe` is 1, `irq_pin` follows `irq_req`, and `gpo` is 0. When the bit is 0, `irq_oe` is 0, `irq_pin` is 0, and `gpo` is 1.
- R9: `loop_en` equals control bit 4. While it is 1, a status read returns `msr_in` with bit 6 (ring indicator) replaced by control bit 2.
- R10: `any_resume` equals control bit 5 and `clk_div4` equals control bit 7 (0 = divide by one, 1 = divide by four).
- R11: Offsets 0, 1, 2, 3 and 5 read as 0, and writes to them change nothing.
- R12: `rd_data` keeps its value in every cycle that is not a selected read, including when `rd_stb` is high while `sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| feat_en | input | 1 | Enhanced-features enable from the feature register |
| msr_in | input | 8 | Modem status byte from the line logic |
| irq_req | input | 1 | Interrupt request from the core |
| irq_pin | output | 1 | Interrupt output value |
| irq_oe | output | 1 | Interrupt output drive enable (0 = high impedance) |
| gpo | output | 1 | General-purpose output |
| loop_en | output | 1 | Internal loopback enable |
| any_resume | output | 1 | Resume transmit on any received character |
| clk_div4 | output | 1 | Prescaler select (1 = divide by four) |

## Verification
A read result appears on `rd_data` one edge after the cycle in which `sel` and `rd_stb` are sampled. The scoreboard records which reads the bus actually performed at each rising edge. At the following falling edge, the monitor compares `rd_data` against the expected byte that the driver queued. A write changes the pin outputs at the write edge itself, because they come from the control register without further logic. The bench checks the pins at the falling edge after that write. The bank selection uses the register and input values present in the read cycle, so each banked read is checked against a model updated by every earlier write.

// File: rtl/uart_ctrl_pkg.sv
package uart_ctrl_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam int OFS_CTL  = 4;
    localparam int OFS_STAT = 6;
    localparam int OFS_AUX  = 7;

    localparam int CB_RING  = 2;
    localparam int CB_IEN   = 3;
    localparam int CB_LOOP  = 4;
    localparam int CB_ANY   = 5;
    localparam int CB_RSVD  = 6;
    localparam int CB_DIV   = 7;
    localparam int SB_RING  = 6;

    typedef enum logic [1:0] {XF_IDLE, XF_WRITE, XF_READ} xfer_e;
    typedef enum logic {VIEW_STD, VIEW_TRIG} view_e;

    function automatic logic ctl_guarded(input int b);
        return (b == CB_ANY) || (b == CB_DIV);
    endfunction
endpackage

// File: rtl/uart_ctl_reg.sv
module uart_ctl_reg
    import uart_ctrl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          feat_en,
    output logic [DW-1:0] ctl_q
);
    for (genvar b = 0; b < DW; b++) begin : g_bit
        if (b == CB_RSVD) begin : g_rsvd
            assign ctl_q[b] = 1'b0;
        end else if (ctl_guarded(b)) begin : g_guard
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 ctl_q[b] <= 1'b0;
                else if (wr_en && feat_en)  ctl_q[b] <= wr_data[b];
            end
        end else begin : g_open
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ctl_q[b] <= 1'b0;
                else if (wr_en)  ctl_q[b] <= wr_data[b];
            end
        end
    end

    // R3
    guard_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !feat_en) |=> (ctl_q[CB_ANY] == $past(ctl_q[CB_ANY]))
                             && (ctl_q[CB_DIV] == $past(ctl_q[CB_DIV])));
endmodule

// File: rtl/uart_bank_store.sv
module uart_bank_store
    import uart_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    input  view_e         view,
    output logic [DW-1:0] trig_ctl,
    output logic [DW-1:0] scratch,
    output logic [DW-1:0] trig_lvl
);
    localparam int NREG = 3;
    logic [NREG-1:0] we;
    logic [DW-1:0]   store_q [NREG];

    always_comb begin
        we    = '0;
        we[0] = wr_fire && (addr == AW'(OFS_STAT)) && (view == VIEW_TRIG);
        we[1] = wr_fire && (addr == AW'(OFS_AUX))  && (view == VIEW_STD);
        we[2] = wr_fire && (addr == AW'(OFS_AUX))  && (view == VIEW_TRIG);
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      store_q[i] <= '0;
            else if (we[i])  store_q[i] <= wr_data;
        end
    end

    assign trig_ctl = store_q[0];
    assign scratch  = store_q[1];
    assign trig_lvl = store_q[2];

    // R7
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && addr == AW'(OFS_STAT) && view == VIEW_STD) |=> $stable(trig_ctl));

    // R6
    aux_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && addr == AW'(OFS_AUX) && view == VIEW_STD) |=> $stable(trig_lvl));
endmodule

// File: rtl/uart_rd_path.sv
module uart_rd_path
    import uart_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    input  view_e         view,
    input  logic [DW-1:0] ctl_q,
    input  logic [DW-1:0] msr_in,
    input  logic [DW-1:0] trig_ctl,
    input  logic [DW-1:0] scratch,
    input  logic [DW-1:0] trig_lvl,
    output logic          wr_fire,
    output xfer_e         xfer_q,
    output logic [DW-1:0] rd_data
);
    xfer_e         xfer_d;
    logic [DW-1:0] stat_eff;
    logic [DW-1:0] mux_d;

    always_comb begin
        if (sel && wr_stb)       xfer_d = XF_WRITE;
        else if (sel && rd_stb)  xfer_d = XF_READ;
        else                     xfer_d = XF_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xfer_q <= XF_IDLE;
        else        xfer_q <= xfer_d;
    end

    always_comb begin
        stat_eff = msr_in;
        if (ctl_q[CB_LOOP]) stat_eff[SB_RING] = ctl_q[CB_RING];
    end

    always_comb begin
        unique case (addr)
            AW'(OFS_CTL):  mux_d = ctl_q;
            AW'(OFS_STAT): mux_d = (view == VIEW_TRIG) ? trig_ctl : stat_eff;
            AW'(OFS_AUX):  mux_d = (view == VIEW_TRIG) ? trig_lvl : scratch;
            default:       mux_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            unique case (xfer_d)
                XF_READ:  rd_data <= mux_d;
                XF_WRITE: rd_data <= rd_data;
                XF_IDLE:  rd_data <= rd_data;
            endcase
        end
    end

    assign wr_fire = (xfer_d == XF_WRITE);

    // R9
    loop_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_d == XF_READ && addr == AW'(OFS_STAT) && view == VIEW_STD && ctl_q[CB_LOOP])
        |=> (rd_data[SB_RING] == $past(ctl_q[CB_RING])));

    // R12
    hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_d != XF_READ) |=> $stable(rd_data));
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          feat_en,
    input  logic [DW-1:0] msr_in,
    input  logic          irq_req,
    output logic          irq_pin,
    output logic          irq_oe,
    output logic          gpo,
    output logic          loop_en,
    output logic          any_resume,
    output logic          clk_div4
);
    logic [DW-1:0] ctl_q;
    logic [DW-1:0] trig_ctl, scratch, trig_lvl;
    logic          wr_fire;
    xfer_e         xfer_q;
    view_e         view;
    logic [AW-1:0] addr_q;

    assign view = (feat_en && ctl_q[CB_RING]) ? VIEW_TRIG : VIEW_STD;

    uart_rd_path #(.DW(DW), .AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(addr), .view(view), .ctl_q(ctl_q), .msr_in(msr_in),
        .trig_ctl(trig_ctl), .scratch(scratch), .trig_lvl(trig_lvl),
        .wr_fire(wr_fire), .xfer_q(xfer_q), .rd_data(rd_data)
    );

    uart_ctl_reg #(.DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire && (addr == AW'(OFS_CTL))),
        .wr_data(wr_data), .feat_en(feat_en), .ctl_q(ctl_q)
    );

    uart_bank_store #(.DW(DW), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(addr),
        .wr_data(wr_data), .view(view),
        .trig_ctl(trig_ctl), .scratch(scratch), .trig_lvl(trig_lvl)
    );

    always_comb begin
        irq_oe     = ctl_q[CB_IEN];
        irq_pin    = ctl_q[CB_IEN] & irq_req;
        gpo        = ~ctl_q[CB_IEN];
        loop_en    = ctl_q[CB_LOOP];
        any_resume = ctl_q[CB_ANY];
        clk_div4   = ctl_q[CB_DIV];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr;
    end

    // R4
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_q == XF_READ && addr_q == AW'(OFS_CTL)) |-> (rd_data[CB_RSVD] == 1'b0));

    // R8
    irq_gpo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> !gpo);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_oe |-> !irq_pin);
endmodule

// File: tb/uart_ctrl_regs_bench.sv
`timescale 1ns/1ps
module uart_ctrl_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       feat_en = 1'b0;
    logic [7:0] msr_in = '0;
    logic       irq_req = 1'b0;
    logic       irq_pin, irq_oe, gpo, loop_en, any_resume, clk_div4;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] m_ctl = 0, m_tc = 0, m_sp = 0, m_tl = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #2 clk = ~clk;

    uart_ctrl_regs u_uart_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .feat_en(feat_en),
        .msr_in(msr_in), .irq_req(irq_req), .irq_pin(irq_pin), .irq_oe(irq_oe),
        .gpo(gpo), .loop_en(loop_en), .any_resume(any_resume), .clk_div4(clk_div4)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic trig_view();
        return feat_en && m_ctl[2];
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1; wr_stb = 1; addr = a; wr_data = d;
        @(negedge clk);
        sel = 0; wr_stb = 0;
        if (a == 3'd4)
            m_ctl = (d & 8'h1F) | (feat_en ? (d & 8'hA0) : (m_ctl & 8'hA0));
        else if (a == 3'd6 && trig_view()) m_tc = d;
        else if (a == 3'd7) begin
            if (trig_view()) m_tl = d; else m_sp = d;
        end
    endtask

    task automatic bus_rd(input logic [2:0] a, input string req);
        logic [7:0] e;
        logic [7:0] st;
        st = msr_in;
        if (m_ctl[4]) st[6] = m_ctl[2];
        case (a)
            3'd4: e = m_ctl;
            3'd6: e = trig_view() ? m_tc : st;
            3'd7: e = trig_view() ? m_tl : m_sp;
            default: e = 8'h00;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        sel = 1; rd_stb = 1; addr = a;
        @(negedge clk);
        sel = 0; rd_stb = 0;
    endtask

    // monitor: note reads taken at each edge, compare at the next falling edge
    always @(posedge clk) rd_seen <= sel && rd_stb && !wr_stb;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL scoreboard actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 pins", {irq_oe, gpo, loop_en, any_resume, clk_div4}, 8'b01000);
        bus_rd(3'd4, "R1 ctl");
        bus_rd(3'd7, "R1 scratch");
        // R3 R4 R2
        bus_wr(3'd4, 8'hFF);
        bus_rd(3'd4, "R3 guarded bits held");
        check("R8 ien pins", {irq_oe, gpo}, 8'b10);
        check("R9 loop_en", loop_en, 1);
        check("R10 div4 held", {any_resume, clk_div4}, 8'b00);
        feat_en = 1;
        bus_wr(3'd4, 8'hFF);
        bus_rd(3'd4, "R4 reserved zero");
        check("R10 div4/resume", {any_resume, clk_div4}, 8'b11);
        feat_en = 0;
        bus_wr(3'd4, 8'h00);
        bus_rd(3'd4, "R3 guarded kept");
        irq_req = 1;
        @(negedge clk);
        check("R8 irq off", {irq_oe, irq_pin, gpo}, 8'b001);
        // R5 R6 banked views
        msr_in = 8'h93;
        feat_en = 1;
        bus_wr(3'd4, 8'h0C);
        check("R8 irq follows", irq_pin, 1);
        irq_req = 0;
        @(negedge clk);
        check("R8 irq low", irq_pin, 0);
        bus_wr(3'd6, 8'h3C);
        bus_wr(3'd7, 8'h5A);
        bus_rd(3'd6, "R5 trig ctl");
        bus_rd(3'd7, "R6 trig lvl");
        feat_en = 0;
        bus_rd(3'd6, "R5 status view");
        bus_wr(3'd7, 8'h11);
        bus_rd(3'd7, "R6 scratch");
        bus_wr(3'd6, 8'hFF);
        feat_en = 1;
        bus_rd(3'd7, "R6 lvl kept");
        bus_rd(3'd6, "R7 status write ignored");
        // R9 loopback
        bus_wr(3'd4, 8'h14);
        feat_en = 0;
        bus_rd(3'd6, "R9 ring high");
        bus_wr(3'd4, 8'h10);
        bus_rd(3'd6, "R9 ring low");
        bus_wr(3'd4, 8'h00);
        msr_in = 8'h40;
        bus_rd(3'd6, "R9 loop off");
        check("R9 loop_en off", loop_en, 0);
        // R11
        for (int a = 0; a < 6; a++) begin
            if (a != 4) bus_wr(3'(a), 8'hFF);
        end
        for (int a = 0; a < 6; a++) begin
            if (a != 4) bus_rd(3'(a), "R11 unmapped");
        end
        bus_rd(3'd4, "R11 ctl untouched");
        bus_rd(3'd7, "R11 scratch untouched");
        // R12
        bus_rd(3'd7, "R12 setup");
        @(negedge clk);
        rd_stb = 1; addr = 3'd6;
        repeat (2) @(negedge clk);
        rd_stb = 0;
        check("R12 hold", rd_data, 8'h11);
        repeat (3) @(negedge clk);
        check("R12 queue drained", 8'(exp_q.size()), 8'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule